// File: doc/BRIEF.md
# Single-Wire Serial Memory Bus Mode Controller

This block is the slave-side mode keeper for a single-wire, Manchester-coded serial memory bus. A bit-level front end turns line activity into one-cycle event strobes: a falling edge on the data line, a detected standby pulse, master acknowledge (MAK), master no-acknowledge (NoMAK), slave acknowledge (SAK) and a missed edge. It also presents every completed byte with its position in the command. From these the controller decides whether the device sleeps in low-power standby, receives a command, or sits in idle where every bit on the line is disregarded until the next standby pulse.

While a command is received the controller checks the device address and the command code, refuses commands that need the array while an internal write is still running, and treats a MAK as illegal after bytes that must be the last of their command. A command closed by NoMAK and then SAK returns the device to standby, and for the commands that alter memory or status that same moment fires the pulse that starts the internal write cycle.

Top module: `swbus_mode_ctrl`

## Requirements
- R1: Out of reset the mode output reads idle (code 0), with the command indication and the write-start pulse low.
- R2: In idle, falling edges, bytes, MAK, NoMAK, SAK and missed edges leave the mode at idle; only a standby pulse moves it.
- R3: A standby pulse puts the block in standby (code 1) from any mode one cycle later, and wins over a missed edge in the same cycle.
- R4: In standby a falling edge moves the block to active (code 2); other events leave it in standby.
- R5: A byte at index 0 that differs from the device address parameter (default 0xA0) sends an active block to idle.
- R6: A byte at index 1 that matches none of the command codes (read 0x03, current-read 0x06, write 0x6C, write-enable 0x96, write-disable 0x91, read-status 0x05, write-status 0x6E, erase-all 0x6D, set-all 0x67) sends the block to idle.
- R7: While the write-busy input is high, read, current-read, write, write-status, set-all and erase-all at index 1 send the block to idle; write-enable, write-disable and read-status are still accepted.
- R8: A missed edge while active sends the block to idle, also when it follows a NoMAK in place of the SAK.
- R9: A MAK after the command byte of write-enable, write-disable, set-all or erase-all, or after the byte at index 2 of write-status, sends the block to idle; a MAK after any other byte keeps it active.
- R10: A NoMAK followed in a later cycle by a SAK returns an active block to standby.
- R11: The write-start output is high for exactly one cycle, the cycle in which standby is entered through R10, and only for write with a byte at index 4 or above, write-status with its byte at index 2 last, and set-all or erase-all ended right after the command byte.
- R12: The command indication is high only in active mode after a legal command byte was accepted, and drops when the mode leaves active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busFall | input | 1 | Falling edge seen on the data line (strobe) |
| stbyPulse | input | 1 | Standby pulse detected (strobe) |
| makRx | input | 1 | Master acknowledge received (strobe) |
| noMakRx | input | 1 | Master no-acknowledge received (strobe) |
| sakRx | input | 1 | Slave acknowledge completed (strobe) |
| missedEdge | input | 1 | Expected edge not found by the front end (strobe) |
| byteDone | input | 1 | A full byte was received (strobe) |
| rxByte | input | 8 | Value of the received byte, valid with byteDone |
| byteIdx | input | IDX_W | Position of the byte in the command, 0 = address, 1 = command |
| wipBusy | input | 1 | Internal write cycle in progress |
| busMode | output | 2 | 0 idle, 1 standby, 2 active |
| cmdActive | output | 1 | A legal command is being received |
| wrStart | output | 1 | One-cycle pulse starting the internal write cycle |

## Verification
The two functions that can meet in one cycle are the standby-pulse return and the missed-edge drop to idle, which pull the mode in opposite directions. The bench raises both strobes together while a command is active and expects standby with the command indication cleared, and it also checks that a missed edge arriving where a SAK was due after NoMAK ends in idle rather than standby and never fires the write pulse.

// File: rtl/swbus_pkg.sv
package swbus_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE    = 2'd0,
    MODE_STANDBY = 2'd1,
    MODE_ACTIVE  = 2'd2
  } busMode_e;

  typedef enum logic [3:0] {
    CLS_NONE,
    CLS_READ,
    CLS_CRRD,
    CLS_WRITE,
    CLS_WREN,
    CLS_WRDI,
    CLS_RDSR,
    CLS_WRSR,
    CLS_ERAL,
    CLS_SETAL
  } cmdClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCmd;
    logic latchCmd;
    logic latchIdx;
  } dpStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic addrOk;
    logic cmdOk;
    logic makBad;
    logic wrQual;
    logic cmdValid;
  } dpStatus_t;

endpackage

// File: rtl/swbus_cmd_dp.sv
module swbus_cmd_dp
  import swbus_pkg::*;
#(
  parameter int          IDX_W         = 4,
  parameter logic [7:0]  DEV_ADDR      = 8'hA0,
  parameter logic [7:0]  CODE_READ     = 8'h03,
  parameter logic [7:0]  CODE_CRRD     = 8'h06,
  parameter logic [7:0]  CODE_WRITE    = 8'h6C,
  parameter logic [7:0]  CODE_WREN     = 8'h96,
  parameter logic [7:0]  CODE_WRDI     = 8'h91,
  parameter logic [7:0]  CODE_RDSR     = 8'h05,
  parameter logic [7:0]  CODE_WRSR     = 8'h6E,
  parameter logic [7:0]  CODE_ERAL     = 8'h6D,
  parameter logic [7:0]  CODE_SETAL    = 8'h67,
  parameter int          WRITE_MIN_IDX = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       rxByte,
  input  logic [IDX_W-1:0] byteIdx,
  input  logic             wipBusy,
  input  dpStrobe_t        strobe,
  output dpStatus_t        status
);

  localparam logic [IDX_W-1:0] CmdIdx      = IDX_W'(1);
  localparam logic [IDX_W-1:0] StatDataIdx = IDX_W'(2);
  localparam logic [IDX_W-1:0] WrMinIdx    = IDX_W'(WRITE_MIN_IDX);

  cmdClass_e        clsQ;
  logic [IDX_W-1:0] lastIdxQ;
  cmdClass_e        clsDec;
  logic             needsArray;

  // command code decode
  always_comb begin
    case (rxByte)
      CODE_READ:  clsDec = CLS_READ;
      CODE_CRRD:  clsDec = CLS_CRRD;
      CODE_WRITE: clsDec = CLS_WRITE;
      CODE_WREN:  clsDec = CLS_WREN;
      CODE_WRDI:  clsDec = CLS_WRDI;
      CODE_RDSR:  clsDec = CLS_RDSR;
      CODE_WRSR:  clsDec = CLS_WRSR;
      CODE_ERAL:  clsDec = CLS_ERAL;
      CODE_SETAL: clsDec = CLS_SETAL;
      default:    clsDec = CLS_NONE;
    endcase
  end

  always_comb begin
    case (clsDec)
      CLS_READ, CLS_CRRD, CLS_WRITE,
      CLS_WRSR, CLS_SETAL, CLS_ERAL: needsArray = 1'b1;
      default:                       needsArray = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clsQ     <= CLS_NONE;
      lastIdxQ <= '0;
    end else if (strobe.clrCmd) begin
      clsQ     <= CLS_NONE;
      lastIdxQ <= '0;
    end else begin
      if (strobe.latchCmd) clsQ <= clsDec;
      if (strobe.latchIdx) lastIdxQ <= byteIdx;
    end
  end

  always_comb begin
    status.addrOk   = (rxByte == DEV_ADDR);
    status.cmdOk    = (clsDec != CLS_NONE) && !(wipBusy && needsArray);
    status.cmdValid = (clsQ != CLS_NONE);

    case (clsQ)
      CLS_WREN, CLS_WRDI, CLS_SETAL, CLS_ERAL:
        status.makBad = (lastIdxQ == CmdIdx);
      CLS_WRSR:
        status.makBad = (lastIdxQ == StatDataIdx);
      default:
        status.makBad = 1'b0;
    endcase

    case (clsQ)
      CLS_WRITE:           status.wrQual = (lastIdxQ >= WrMinIdx);
      CLS_WRSR:            status.wrQual = (lastIdxQ == StatDataIdx);
      CLS_SETAL, CLS_ERAL: status.wrQual = (lastIdxQ == CmdIdx);
      default:             status.wrQual = 1'b0;
    endcase
  end

endmodule

// File: rtl/swbus_mode_fsm.sv
module swbus_mode_fsm
  import swbus_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busFall,
  input  logic             stbyPulse,
  input  logic             makRx,
  input  logic             noMakRx,
  input  logic             sakRx,
  input  logic             missedEdge,
  input  logic             byteDone,
  input  logic [IDX_W-1:0] byteIdx,
  input  dpStatus_t        status,
  output dpStrobe_t        strobe,
  output busMode_e         modeQ,
  output logic             cmdActive,
  output logic             wrStart
);

  localparam logic [IDX_W-1:0] AddrIdx = IDX_W'(0);
  localparam logic [IDX_W-1:0] CmdIdx  = IDX_W'(1);

  busMode_e modeD;
  logic     endPendQ, endPendD;
  logic     wrStartQ, wrStartD;

  always_comb begin
    modeD    = modeQ;
    endPendD = endPendQ;
    wrStartD = 1'b0;
    strobe   = '0;

    if (stbyPulse) begin
      modeD         = MODE_STANDBY;
      endPendD      = 1'b0;
      strobe.clrCmd = 1'b1;
    end else begin
      case (modeQ)
        MODE_IDLE: begin
          // traffic disregarded
        end
        MODE_STANDBY: begin
          if (busFall) begin
            modeD         = MODE_ACTIVE;
            endPendD      = 1'b0;
            strobe.clrCmd = 1'b1;
          end
        end
        MODE_ACTIVE: begin
          if (missedEdge) begin
            modeD         = MODE_IDLE;
            endPendD      = 1'b0;
            strobe.clrCmd = 1'b1;
          end else if (endPendQ) begin
            if (sakRx) begin
              modeD         = MODE_STANDBY;
              endPendD      = 1'b0;
              wrStartD      = status.wrQual;
              strobe.clrCmd = 1'b1;
            end
          end else if (byteDone) begin
            if ((byteIdx == AddrIdx && !status.addrOk) ||
                (byteIdx == CmdIdx && !status.cmdOk)) begin
              modeD         = MODE_IDLE;
              strobe.clrCmd = 1'b1;
            end else begin
              strobe.latchIdx = 1'b1;
              strobe.latchCmd = (byteIdx == CmdIdx);
            end
          end else if (makRx) begin
            if (status.makBad) begin
              modeD         = MODE_IDLE;
              strobe.clrCmd = 1'b1;
            end
          end else if (noMakRx) begin
            endPendD = 1'b1;
          end
        end
        default: begin
          modeD         = MODE_IDLE;
          endPendD      = 1'b0;
          strobe.clrCmd = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_IDLE;
      endPendQ <= 1'b0;
      wrStartQ <= 1'b0;
    end else begin
      modeQ    <= modeD;
      endPendQ <= endPendD;
      wrStartQ <= wrStartD;
    end
  end

  assign wrStart   = wrStartQ;
  assign cmdActive = (modeQ == MODE_ACTIVE) && status.cmdValid;

endmodule

// File: rtl/swbus_mode_ctrl.sv
module swbus_mode_ctrl
  import swbus_pkg::*;
#(
  parameter int          IDX_W         = 4,
  parameter logic [7:0]  DEV_ADDR      = 8'hA0,
  parameter logic [7:0]  CODE_READ     = 8'h03,
  parameter logic [7:0]  CODE_CRRD     = 8'h06,
  parameter logic [7:0]  CODE_WRITE    = 8'h6C,
  parameter logic [7:0]  CODE_WREN     = 8'h96,
  parameter logic [7:0]  CODE_WRDI     = 8'h91,
  parameter logic [7:0]  CODE_RDSR     = 8'h05,
  parameter logic [7:0]  CODE_WRSR     = 8'h6E,
  parameter logic [7:0]  CODE_ERAL     = 8'h6D,
  parameter logic [7:0]  CODE_SETAL    = 8'h67,
  parameter int          WRITE_MIN_IDX = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busFall,
  input  logic             stbyPulse,
  input  logic             makRx,
  input  logic             noMakRx,
  input  logic             sakRx,
  input  logic             missedEdge,
  input  logic             byteDone,
  input  logic [7:0]       rxByte,
  input  logic [IDX_W-1:0] byteIdx,
  input  logic             wipBusy,
  output logic [1:0]       busMode,
  output logic             cmdActive,
  output logic             wrStart
);

  dpStrobe_t dpStrobe;
  dpStatus_t dpStatus;
  busMode_e  modeQ;

  swbus_cmd_dp #(
    .IDX_W(IDX_W), .DEV_ADDR(DEV_ADDR),
    .CODE_READ(CODE_READ), .CODE_CRRD(CODE_CRRD), .CODE_WRITE(CODE_WRITE),
    .CODE_WREN(CODE_WREN), .CODE_WRDI(CODE_WRDI), .CODE_RDSR(CODE_RDSR),
    .CODE_WRSR(CODE_WRSR), .CODE_ERAL(CODE_ERAL), .CODE_SETAL(CODE_SETAL),
    .WRITE_MIN_IDX(WRITE_MIN_IDX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .byteIdx(byteIdx),
    .wipBusy(wipBusy), .strobe(dpStrobe), .status(dpStatus)
  );

  swbus_mode_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rstN(rstN), .busFall(busFall), .stbyPulse(stbyPulse),
    .makRx(makRx), .noMakRx(noMakRx), .sakRx(sakRx),
    .missedEdge(missedEdge), .byteDone(byteDone), .byteIdx(byteIdx),
    .status(dpStatus), .strobe(dpStrobe), .modeQ(modeQ),
    .cmdActive(cmdActive), .wrStart(wrStart)
  );

  assign busMode = modeQ;

endmodule

// File: rtl/swbus_mode_chk.sv
module swbus_mode_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busFall,
  input logic       stbyPulse,
  input logic       missedEdge,
  input logic [1:0] busMode,
  input logic       cmdActive,
  input logic       wrStart
);

  localparam logic [1:0] MIdle = 2'd0;
  localparam logic [1:0] MStby = 2'd1;
  localparam logic [1:0] MAct  = 2'd2;

  p_stby_any_r3: assert property (@(posedge clk) disable iff (!rstN)
    stbyPulse |=> busMode == MStby);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busMode == MIdle && !stbyPulse) |=> busMode == MIdle);

  p_fall_wake_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busMode == MStby && busFall && !stbyPulse) |=> busMode == MAct);

  p_missed_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busMode == MAct && missedEdge && !stbyPulse) |=> busMode == MIdle);

  p_wr_one_cycle_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |=> !wrStart);

  p_wr_at_stby_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |-> (busMode == MStby && $past(busMode) == MAct));

  p_cmd_in_active_r12: assert property (@(posedge clk) disable iff (!rstN)
    cmdActive |-> busMode == MAct);

  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    busMode != 2'd3);

endmodule

bind swbus_mode_ctrl swbus_mode_chk u_chk (
  .clk(clk), .rstN(rstN), .busFall(busFall), .stbyPulse(stbyPulse),
  .missedEdge(missedEdge), .busMode(busMode), .cmdActive(cmdActive),
  .wrStart(wrStart)
);

// File: tb/swbus_mode_ctrl_tb.sv
`timescale 1ns/1ps
module swbus_mode_ctrl_tb;

  localparam int IDX_W = 4;
  // event mask bits
  localparam int E_FALL = 0, E_STBY = 1, E_MAK = 2, E_NOMAK = 3;
  localparam int E_SAK = 4, E_MISS = 5, E_BYTE = 6;
  localparam logic [1:0] I = 2'd0, S = 2'd1, A = 2'd2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busFall = 0, stbyPulse = 0, makRx = 0, noMakRx = 0, sakRx = 0;
  logic missedEdge = 0, byteDone = 0, wipBusy = 0;
  logic [7:0] rxByte = '0;
  logic [IDX_W-1:0] byteIdx = '0;
  logic [1:0] busMode;
  logic cmdActive, wrStart;

  int nTests = 0, nFail = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0] m;
    logic       a;
    logic       w;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  swbus_mode_ctrl #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rstN(rstN), .busFall(busFall), .stbyPulse(stbyPulse),
    .makRx(makRx), .noMakRx(noMakRx), .sakRx(sakRx),
    .missedEdge(missedEdge), .byteDone(byteDone), .rxByte(rxByte),
    .byteIdx(byteIdx), .wipBusy(wipBusy), .busMode(busMode),
    .cmdActive(cmdActive), .wrStart(wrStart)
  );

  // driver: one cycle of stimulus, expected result queued
  task automatic step(input logic [6:0] ev, input logic [7:0] b,
                      input int idx, input logic busy,
                      input logic [1:0] em, input logic ea, input logic ew,
                      input string tag);
    exp_t e;
    busFall    = ev[E_FALL];
    stbyPulse  = ev[E_STBY];
    makRx      = ev[E_MAK];
    noMakRx    = ev[E_NOMAK];
    sakRx      = ev[E_SAK];
    missedEdge = ev[E_MISS];
    byteDone   = ev[E_BYTE];
    rxByte     = b;
    byteIdx    = IDX_W'(idx);
    wipBusy    = busy;
    e.m = em; e.a = ea; e.w = ew; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic ev1(input int bitN, input logic [1:0] em, input logic ea,
                     input logic ew, input string tag);
    logic [6:0] m;
    m = '0;
    m[bitN] = 1'b1;
    step(m, 8'h00, 0, 1'b0, em, ea, ew, tag);
  endtask

  task automatic byt(input logic [7:0] b, input int idx, input logic busy,
                     input logic [1:0] em, input logic ea, input string tag);
    step(7'b1 << E_BYTE, b, idx, busy, em, ea, 1'b0, tag);
  endtask

  // monitor: compares between edges
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        nTests++;
        if (busMode !== e.m || cmdActive !== e.a || wrStart !== e.w) begin
          nFail++;
          $display("FAIL %s: mode/act/wr got %0d/%0b/%0b expected %0d/%0b/%0b",
                   e.tag, busMode, cmdActive, wrStart, e.m, e.a, e.w);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    nTests++;
    nFail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, before release
    nTests++;
    if (busMode !== I || cmdActive !== 1'b0 || wrStart !== 1'b0) begin
      nFail++;
      $display("FAIL R1: got %0d/%0b/%0b expected 0/0/0", busMode, cmdActive, wrStart);
    end
    rstN = 1'b1;
    step('0, 8'h00, 0, 0, I, 0, 0, "R1 idle after reset");

    // R2 idle ignores traffic
    ev1(E_FALL, I, 0, 0, "R2 fall ignored");
    byt(8'hA0, 0, 0, I, 0, "R2 byte ignored");
    byt(8'h03, 1, 0, I, 0, "R2 cmd ignored");
    ev1(E_NOMAK, I, 0, 0, "R2 nomak ignored");
    ev1(E_SAK, I, 0, 0, "R2 sak ignored");
    ev1(E_MISS, I, 0, 0, "R2 missed ignored");

    // R3 leave idle
    ev1(E_STBY, S, 0, 0, "R3 idle to standby");
    // R4
    ev1(E_MAK, S, 0, 0, "R4 mak in standby");
    ev1(E_SAK, S, 0, 0, "R4 sak in standby");
    ev1(E_FALL, A, 0, 0, "R4 fall wakes");

    // read command, R12, R9 (mak elsewhere), R10
    byt(8'hA0, 0, 0, A, 0, "R5 address ok");
    byt(8'h03, 1, 0, A, 1, "R12 read accepted");
    ev1(E_MAK, A, 1, 0, "R9 mak after read cmd");
    byt(8'h00, 2, 0, A, 1, "R12 addr hi");
    ev1(E_MAK, A, 1, 0, "R9 mak after addr");
    ev1(E_NOMAK, A, 1, 0, "R10 nomak");
    step('0, 8'h00, 0, 0, A, 1, 0, "R10 wait for sak");
    ev1(E_SAK, S, 0, 0, "R10 R11 read ends, no write pulse");

    // full write, R11
    ev1(E_FALL, A, 0, 0, "R4 fall");
    byt(8'hA0, 0, 0, A, 0, "R5 addr");
    byt(8'h6C, 1, 0, A, 1, "R12 write accepted");
    ev1(E_MAK, A, 1, 0, "R9");
    byt(8'h01, 2, 0, A, 1, "R11 hi");
    ev1(E_MAK, A, 1, 0, "R9");
    byt(8'h02, 3, 0, A, 1, "R11 lo");
    ev1(E_MAK, A, 1, 0, "R9");
    byt(8'h5A, 4, 0, A, 1, "R11 data");
    ev1(E_NOMAK, A, 1, 0, "R11 nomak");
    ev1(E_SAK, S, 0, 1, "R11 write pulse");
    step('0, 8'h00, 0, 0, S, 0, 0, "R11 pulse one cycle");

    // write too short, R11
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'hA0, 0, 0, A, 0, "R5");
    byt(8'h6C, 1, 0, A, 1, "R12");
    ev1(E_MAK, A, 1, 0, "R9");
    byt(8'h01, 2, 0, A, 1, "R11 short write");
    ev1(E_NOMAK, A, 1, 0, "R11");
    ev1(E_SAK, S, 0, 0, "R11 short write no pulse");

    // R5 bad address
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'h55, 0, 0, I, 0, "R5 address mismatch");
    ev1(E_FALL, I, 0, 0, "R2 idle after mismatch");
    ev1(E_STBY, S, 0, 0, "R3");

    // R6 unknown code
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'hA0, 0, 0, A, 0, "R5");
    byt(8'h42, 1, 0, I, 0, "R6 unknown command");
    ev1(E_STBY, S, 0, 0, "R3");

    // R7 busy rejection and allowed commands
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'hA0, 0, 1, A, 0, "R5");
    byt(8'h6C, 1, 1, I, 0, "R7 write while busy");
    ev1(E_STBY, S, 0, 0, "R3");
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'hA0, 0, 1, A, 0, "R5");
    byt(8'h06, 1, 1, I, 0, "R7 current read while busy");
    ev1(E_STBY, S, 0, 0, "R3");
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'hA0, 0, 1, A, 0, "R5");
    byt(8'h05, 1, 1, A, 1, "R7 status read while busy");
    ev1(E_STBY, S, 0, 0, "R3 R12 active to standby");
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'hA0, 0, 1, A, 0, "R5");
    byt(8'h96, 1, 1, A, 1, "R7 write enable while busy");
    // R9 mak after write enable
    ev1(E_MAK, I, 0, 0, "R9 mak after write enable");
    ev1(E_STBY, S, 0, 0, "R3");

    // R9 write status
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'hA0, 0, 0, A, 0, "R5");
    byt(8'h6E, 1, 0, A, 1, "R12 write status");
    ev1(E_MAK, A, 1, 0, "R9 mak after status cmd ok");
    byt(8'h0C, 2, 0, A, 1, "R9 status data");
    ev1(E_MAK, I, 0, 0, "R9 mak after status data");
    ev1(E_STBY, S, 0, 0, "R3");

    // R11 write status proper
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'hA0, 0, 0, A, 0, "R5");
    byt(8'h6E, 1, 0, A, 1, "R12");
    ev1(E_MAK, A, 1, 0, "R9");
    byt(8'h0C, 2, 0, A, 1, "R11 status data");
    ev1(E_NOMAK, A, 1, 0, "R11");
    ev1(E_SAK, S, 0, 1, "R11 status write pulse");

    // R11 erase-all and set-all, R9 mak after set-all
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'hA0, 0, 0, A, 0, "R5");
    byt(8'h6D, 1, 0, A, 1, "R12 erase all");
    ev1(E_NOMAK, A, 1, 0, "R11");
    ev1(E_SAK, S, 0, 1, "R11 erase pulse");
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'hA0, 0, 0, A, 0, "R5");
    byt(8'h67, 1, 0, A, 1, "R12 set all");
    ev1(E_MAK, I, 0, 0, "R9 mak after set all");
    ev1(E_STBY, S, 0, 0, "R3");

    // write disable ends without pulse
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'hA0, 0, 0, A, 0, "R5");
    byt(8'h91, 1, 0, A, 1, "R12 write disable");
    ev1(E_NOMAK, A, 1, 0, "R10");
    ev1(E_SAK, S, 0, 0, "R11 no pulse for write disable");

    // R8 missed edge in place of SAK
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'hA0, 0, 0, A, 0, "R5");
    byt(8'h6D, 1, 0, A, 1, "R12");
    ev1(E_NOMAK, A, 1, 0, "R8");
    ev1(E_MISS, I, 0, 0, "R8 missing sak goes idle");
    ev1(E_SAK, I, 0, 0, "R2 late sak ignored");
    ev1(E_STBY, S, 0, 0, "R3");
    ev1(E_FALL, A, 0, 0, "R4");
    ev1(E_MISS, I, 0, 0, "R8 missed edge active");
    ev1(E_STBY, S, 0, 0, "R3");

    // R3 conflict: standby pulse and missed edge together
    ev1(E_FALL, A, 0, 0, "R4");
    byt(8'hA0, 0, 0, A, 0, "R5");
    byt(8'h03, 1, 0, A, 1, "R12");
    step((7'b1 << E_STBY) | (7'b1 << E_MISS), 8'h00, 0, 0, S, 0, 0,
         "R3 standby beats missed edge");
    step('0, 8'h00, 0, 0, S, 0, 0, "R3 stays standby");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule